// File: doc/BRIEF.md
# Fully Associative Write-Back Cache

This block is a byte-addressed cache for a 16-bit address space. It stores 128 lines of 16 bytes each, 2 KB of data in total. Any memory block may sit in any line. A processor issues single-byte reads and writes. The cache answers each request with a ready pulse and a flag that says whether the request hit. Misses go to a line-wide memory port. That port fetches whole blocks and writes dirty victims back to memory.

The upper twelve address bits form the tag, and the lowest four bits select a byte within the line. There is no index field. Every stored tag is compared with the request in the same cycle. A miss first uses the lowest-numbered empty line. Only when every line holds data does a round-robin pointer choose a victim. If that victim has been modified, its contents go out to memory before the new block is fetched. A write miss allocates a line: the block is fetched, then the byte is merged into it.

The processor holds `cpu_req` and its fields steady until it sees `cpu_ready`. The memory side holds `mem_req` and its fields steady until it sees `mem_ack`.

Top module: `fa_cache_top`

## Requirements
- R1: The tag is `cpu_addr[15:4]` and the byte offset is `cpu_addr[3:0]`. Any two addresses with the same tag refer to the same line, so once a block is resident, every offset within it hits.
- R2: After reset, no line is valid, and `cpu_ready` and `mem_req` are low. The first access to any address is a miss.
- R3: A hit asserts `cpu_ready` with `cpu_hit`=1 exactly one cycle after the request is presented. It causes no memory-side request, and a read returns the stored byte in `cpu_rdata`.
- R4: While at least one line is invalid, a miss fills the lowest-numbered invalid line. Nothing is evicted until all 128 lines are valid.
- R5: When all lines are valid, the victim is the line named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, after each such eviction.
- R6: A valid, dirty victim is written back first. The memory side sees a write (`mem_we`=1) of the victim's 16 bytes, with `mem_addr` set to the victim's tag. Byte i of `mem_wline` sits in bits [8i+7:8i]. The fill read follows the write.
- R7: A clean or invalid victim causes no write-back. Only the fill read is issued.
- R8: A write merges `cpu_wdata` into the addressed byte and marks the line dirty. A write miss first fetches the block, then merges the byte. Later reads return the written value.
- R9: At most one line's tag comparison matches at any time.
- R10: A memory-side request carries the 12-bit block number in `mem_addr`. It holds `mem_req`, `mem_we` and `mem_addr` stable until `mem_ack`.
- R11: A request that missed completes with `cpu_ready` and `cpu_hit`=0. A read miss returns the byte from the freshly loaded block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | 1 when the completed request hit |
| mem_req | output | 1 | Memory-side request |
| mem_we | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_addr | output | 12 | Block number (address bits 15:4) |
| mem_wline | output | 128 | Line data for write-back |
| mem_rline | input | 128 | Line data returned for a fetch, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle completion of a memory-side request |

## Verification
The bench fills all 128 lines and checks that every one of them still hits. A design that evicted early, or picked a line other than the lowest empty one, would miss on a block it should hold. Once the cache is full, it forces evictions in turn. It checks which block is gone and whether a write-back went out, with the right tag and bytes. A pointer that starts wrong or skips would lose the wrong block. A design that wrote back clean lines, or dropped dirty ones, would show up in the write-back counts or as stale data on a later refill. Write misses and offset aliasing within a block are also driven, followed by a long random mix over more blocks than the cache holds.

// File: rtl/fa_cache_pkg.sv
// Shared definitions for the fully associative cache.
// Assumes: nothing beyond IEEE 1800-2017.
package fa_cache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WB   = 2'd1,
        ST_FILL = 2'd2,
        ST_RESP = 2'd3
    } ctrl_state_e;
endpackage

// File: rtl/fa_tag_store.sv
// Per-line tag, valid and dirty state, plus a parallel compare of every
// stored tag against the lookup tag. Encodes the single match to an index.
// Assumes: at most one valid line carries any given tag (the allocator
// only loads a tag after a miss on it).
module fa_tag_store #(
    parameter int TAG_W = 12,
    parameter int LINES = 128,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lookup_tag_i,
    output logic [LINES-1:0] match_o,
    output logic             hit_o,
    output logic [IDX_W-1:0] hit_idx_o,
    output logic [LINES-1:0] valid_o,
    output logic [LINES-1:0] dirty_o,
    input  logic             load_en_i,
    input  logic [IDX_W-1:0] load_idx_i,
    input  logic [TAG_W-1:0] load_tag_i,
    input  logic             mark_dirty_i,
    input  logic [IDX_W-1:0] mark_idx_i,
    input  logic [IDX_W-1:0] read_idx_i,
    output logic [TAG_W-1:0] read_tag_o
);
    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;

    // Valid and dirty bits: load sets valid and clears dirty, a write sets dirty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (load_en_i && load_idx_i == IDX_W'(i)) begin
                    valid_q[i] <= 1'b1;
                    dirty_q[i] <= 1'b0;
                end else if (mark_dirty_i && mark_idx_i == IDX_W'(i)) begin
                    dirty_q[i] <= 1'b1;
                end
            end
        end
    end

    // Tag storage: written only when a line is loaded.
    always_ff @(posedge clk) begin
        if (load_en_i) begin
            tag_q[load_idx_i] <= load_tag_i;
        end
    end

    // One comparator per line, all evaluated in the same cycle.
    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign match_o[g] = valid_q[g] && (tag_q[g] == lookup_tag_i);
    end

    // Encode the (one-hot) match vector into a line index.
    always_comb begin
        hit_idx_o = '0;
        for (int i = 0; i < LINES; i++) begin
            if (match_o[i]) hit_idx_o = hit_idx_o | IDX_W'(i);
        end
    end

    assign hit_o      = |match_o;
    assign valid_o    = valid_q;
    assign dirty_o    = dirty_q;
    assign read_tag_o = tag_q[read_idx_i];

    // R9: never two lines matching the same tag
    a_r9_match_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_o));

    // R8: bytes are only ever merged into a line that currently matches
    a_r8_dirty_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        mark_dirty_i |-> match_o[mark_idx_i]);
endmodule

// File: rtl/fa_victim_sel.sv
// Chooses the line to fill on a miss: the lowest-numbered invalid line
// while any exists, otherwise a round-robin pointer that steps after use.
// Assumes: LINES is a power of two so the pointer wraps by truncation.
module fa_victim_sel #(
    parameter int LINES = 128,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] valid_i,
    input  logic             advance_i,
    output logic [IDX_W-1:0] victim_idx_o,
    output logic             full_o
);
    logic [IDX_W-1:0] rr_ptr_q;
    logic [IDX_W-1:0] free_idx;

    // Priority search: the last assignment wins, so the scan runs downward.
    always_comb begin
        free_idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (!valid_i[i]) free_idx = IDX_W'(i);
        end
    end

    assign full_o       = &valid_i;
    assign victim_idx_o = full_o ? rr_ptr_q : free_idx;

    // Round-robin pointer: steps only when it supplied the victim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr_q <= '0;
        end else if (advance_i && full_o) begin
            rr_ptr_q <= rr_ptr_q + 1'b1;
        end
    end

    // R5: once full, each eviction moves the victim choice on by one line
    a_r5_rr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && full_o) |=> (victim_idx_o == IDX_W'($past(victim_idx_o) + 1'b1)));
endmodule

// File: rtl/fa_ctrl.sv
// Miss-handling sequencer: lookup, optional write-back, fill, response.
// Assumes the processor holds its request stable until cpu_ready, and the
// memory side acknowledges each request with a one-cycle mem_ack.
module fa_ctrl
    import fa_cache_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req_i,
    input  logic             cpu_we_i,
    input  logic             hit_i,
    input  logic [IDX_W-1:0] victim_idx_i,
    input  logic             victim_needs_wb_i,
    input  logic             mem_ack_i,
    output ctrl_state_e      state_o,
    output logic [IDX_W-1:0] vic_idx_o,
    output logic             missed_o,
    output logic             accept_o,
    output logic             write_en_o,
    output logic             load_en_o,
    output logic             advance_o,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic             cpu_ready_o
);
    ctrl_state_e      state_q, state_d;
    logic [IDX_W-1:0] vic_q;
    logic             miss_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cpu_req_i) begin
                if (hit_i)                  state_d = ST_RESP;
                else if (victim_needs_wb_i) state_d = ST_WB;
                else                        state_d = ST_FILL;
            end
            ST_WB:   if (mem_ack_i) state_d = ST_FILL;
            ST_FILL: if (mem_ack_i) state_d = ST_IDLE;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register, latched victim and the miss flag for the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vic_q   <= '0;
            miss_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (advance_o) begin
                vic_q  <= victim_idx_i;
                miss_q <= 1'b1;
            end else if (state_q == ST_RESP) begin
                miss_q <= 1'b0;
            end
        end
    end

    assign accept_o    = (state_q == ST_IDLE) && cpu_req_i && hit_i;
    assign write_en_o  = accept_o && cpu_we_i;
    assign advance_o   = (state_q == ST_IDLE) && cpu_req_i && !hit_i;
    assign load_en_o   = (state_q == ST_FILL) && mem_ack_i;
    assign mem_req_o   = (state_q == ST_WB) || (state_q == ST_FILL);
    assign mem_we_o    = (state_q == ST_WB);
    assign cpu_ready_o = (state_q == ST_RESP);
    assign state_o     = state_q;
    assign vic_idx_o   = vic_q;
    assign missed_o    = miss_q;

    // R3: completion is a single-cycle pulse
    a_r3_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready_o |=> !cpu_ready_o);

    // R6: a finished write-back is followed directly by the fill read
    a_r6_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && mem_ack_i) |=> (mem_req_o && !mem_we_o));

    // R10: an unacknowledged memory request keeps its direction
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o)));

    // R3: no memory traffic while answering the processor
    a_r3_no_mem_on_resp: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready_o |-> !mem_req_o);
endmodule

// File: rtl/fa_cache_top.sv
// Fully associative write-back cache: 128 lines of 16 bytes, 16-bit byte
// addresses, parallel tag compare, lowest-free then round-robin replacement.
// Assumes the processor request and memory acknowledge protocols described
// in fa_ctrl; the data array is not reset (valid bits guard it).
module fa_cache_top #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4,
    parameter int LINES  = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_req,
    input  logic                     cpu_we,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [7:0]               cpu_wdata,
    output logic [7:0]               cpu_rdata,
    output logic                     cpu_ready,
    output logic                     cpu_hit,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [ADDR_W-OFF_W-1:0]  mem_addr,
    output logic [8*(2**OFF_W)-1:0]  mem_wline,
    input  logic [8*(2**OFF_W)-1:0]  mem_rline,
    input  logic                     mem_ack
);
    import fa_cache_pkg::*;

    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int LINE_W = 8 * (2 ** OFF_W);
    localparam int IDX_W  = $clog2(LINES);

    logic [TAG_W-1:0]  req_tag;
    logic [OFF_W-1:0]  req_off;
    logic [LINES-1:0]  match_vec, valid_vec, dirty_vec;
    logic              hit;
    logic [IDX_W-1:0]  hit_idx, victim_idx, vic_idx;
    logic              full;
    logic [TAG_W-1:0]  vic_tag;
    ctrl_state_e       state;
    logic              missed, accept, write_en, load_en, advance;
    logic [LINE_W-1:0] data_q [LINES];
    logic [7:0]        rdata_q;

    assign req_tag = cpu_addr[ADDR_W-1:OFF_W];
    assign req_off = cpu_addr[OFF_W-1:0];

    fa_tag_store #(.TAG_W(TAG_W), .LINES(LINES), .IDX_W(IDX_W)) tags_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .lookup_tag_i (req_tag),
        .match_o      (match_vec),
        .hit_o        (hit),
        .hit_idx_o    (hit_idx),
        .valid_o      (valid_vec),
        .dirty_o      (dirty_vec),
        .load_en_i    (load_en),
        .load_idx_i   (vic_idx),
        .load_tag_i   (req_tag),
        .mark_dirty_i (write_en),
        .mark_idx_i   (hit_idx),
        .read_idx_i   (vic_idx),
        .read_tag_o   (vic_tag)
    );

    fa_victim_sel #(.LINES(LINES), .IDX_W(IDX_W)) vsel_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_i      (valid_vec),
        .advance_i    (advance),
        .victim_idx_o (victim_idx),
        .full_o       (full)
    );

    fa_ctrl #(.IDX_W(IDX_W)) ctrl_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .cpu_req_i         (cpu_req),
        .cpu_we_i          (cpu_we),
        .hit_i             (hit),
        .victim_idx_i      (victim_idx),
        .victim_needs_wb_i (valid_vec[victim_idx] && dirty_vec[victim_idx]),
        .mem_ack_i         (mem_ack),
        .state_o           (state),
        .vic_idx_o         (vic_idx),
        .missed_o          (missed),
        .accept_o          (accept),
        .write_en_o        (write_en),
        .load_en_o         (load_en),
        .advance_o         (advance),
        .mem_req_o         (mem_req),
        .mem_we_o          (mem_we),
        .cpu_ready_o       (cpu_ready)
    );

    // Data array: whole-line load on fill, single-byte merge on write hit.
    always_ff @(posedge clk) begin
        if (load_en) begin
            data_q[vic_idx] <= mem_rline;
        end else if (write_en) begin
            data_q[hit_idx][{req_off, 3'b000} +: 8] <= cpu_wdata;
        end
    end

    // Response byte captured when a hit is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (accept) begin
            rdata_q <= cpu_we ? cpu_wdata : data_q[hit_idx][{req_off, 3'b000} +: 8];
        end
    end

    assign cpu_rdata = rdata_q;
    assign cpu_hit   = cpu_ready && !missed;
    assign mem_addr  = (state == ST_WB) ? vic_tag : req_tag;
    assign mem_wline = data_q[vic_idx];

    // R4: a fill lands in an invalid line unless every line is valid
    a_r4_fill_free_first: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> (!valid_vec[vic_idx] || full));

    // R10: block number stays put until the memory side acknowledges
    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> $stable(mem_addr));
endmodule

// File: tb/fa_cache_top_tb_top.sv
module fa_cache_top_tb_top;
    localparam int MEM_DELAY = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0]  cpu_addr = '0;
    logic [7:0]   cpu_wdata = '0;
    logic [7:0]   cpu_rdata;
    logic         cpu_ready, cpu_hit;
    logic         mem_req, mem_we, mem_ack;
    logic [11:0]  mem_addr;
    logic [127:0] mem_wline, mem_rline;

    int checks = 0, failures = 0, cycles = 0;
    int wb_cnt = 0, fill_cnt = 0, last_wb = -1, mem_wait = 0;

    logic [7:0] ref_mem [int];   // coherent view seen by the processor
    logic [7:0] back_mem [int];  // contents of the memory behind the cache

    bit m_valid [128];
    bit m_dirty [128];
    int m_tag [128];
    int m_ptr = 0;

    fa_cache_top dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wline(mem_wline),
        .mem_rline(mem_rline), .mem_ack(mem_ack)
    );

    always #10 clk = ~clk;  // 50 MHz

    function automatic logic [7:0] init_byte(int a);
        return 8'((a * 37) ^ (a >> 8) ^ 8'h5A);
    endfunction

    function automatic logic [7:0] ref_get(int a);
        return ref_mem.exists(a) ? ref_mem[a] : init_byte(a);
    endfunction

    function automatic logic [7:0] back_get(int a);
        return back_mem.exists(a) ? back_mem[a] : init_byte(a);
    endfunction

    task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Watchdog: expiry counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            failures++;
            $display("FAIL R3 watchdog expired actual=%0d expected<=190000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Memory model: answers each request after MEM_DELAY cycles with a one-cycle ack.
    initial begin
        mem_ack = 1'b0;
        mem_rline = '0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (rst_n && mem_req) begin
                mem_wait++;
                if (mem_wait >= MEM_DELAY) begin
                    mem_wait = 0;
                    if (mem_we) begin
                        wb_cnt++;
                        last_wb = int'(mem_addr);
                        for (int b = 0; b < 16; b++) begin
                            chk("R6", "writeback byte", mem_wline[8*b +: 8],
                                ref_get({mem_addr, 4'(b)}));
                            back_mem[{mem_addr, 4'(b)}] = mem_wline[8*b +: 8];
                        end
                    end else begin
                        fill_cnt++;
                        for (int b = 0; b < 16; b++)
                            mem_rline[8*b +: 8] = back_get({mem_addr, 4'(b)});
                    end
                    mem_ack = 1'b1;
                end
            end
        end
    end

    // One processor access, checked against the reference model.
    task automatic access(bit we, logic [15:0] a, logic [7:0] d, string rq);
        int tg = int'(a[15:4]);
        int idx = -1;
        bit exp_hit, exp_wb = 0;
        int exp_wb_tag = -1, wb0, f0, lat = 0;
        logic [7:0] exp_rd;
        string hr;
        for (int i = 0; i < 128; i++) if (m_valid[i] && m_tag[i] == tg) idx = i;
        exp_hit = (idx >= 0);
        if (!exp_hit) begin
            for (int i = 127; i >= 0; i--) if (!m_valid[i]) idx = i;
            if (idx < 0) begin
                idx = m_ptr;
                m_ptr = (m_ptr + 1) % 128;
            end
            if (m_valid[idx] && m_dirty[idx]) begin
                exp_wb = 1;
                exp_wb_tag = m_tag[idx];
            end
            m_valid[idx] = 1; m_tag[idx] = tg; m_dirty[idx] = 0;
        end
        if (we) m_dirty[idx] = 1;
        exp_rd = we ? d : ref_get(int'(a));
        wb0 = wb_cnt; f0 = fill_cnt;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_ready && lat < 1000);
        hr = (rq != "") ? rq : (exp_hit ? "R3" : "R11");
        chk(hr, "hit flag", cpu_hit, exp_hit);
        chk(hr, "data", cpu_rdata, exp_rd);
        if (exp_hit) begin
            chk("R3", "hit latency", lat, 1);
            chk("R3", "fills on hit", fill_cnt - f0, 0);
        end else begin
            chk("R11", "fills on miss", fill_cnt - f0, 1);
        end
        if (exp_wb) begin
            chk("R6", "writebacks", wb_cnt - wb0, 1);
            chk("R6", "writeback tag", last_wb, exp_wb_tag);
        end else begin
            chk("R7", "writebacks", wb_cnt - wb0, 0);
        end
        cpu_req = 1'b0;
        if (we) ref_mem[int'(a)] = d;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk("R2", "ready in reset", cpu_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", "ready after reset", cpu_ready, 0);
        chk("R2", "mem_req after reset", mem_req, 0);

        // First access misses; offsets in the same block then hit.
        access(0, 16'h1234, 8'h00, "R2");
        access(0, 16'h123F, 8'h00, "R1");
        access(0, 16'h1230, 8'h00, "R1");
        access(1, 16'h1235, 8'hA5, "R8");
        access(0, 16'h1235, 8'h00, "R8");

        // Fill the remaining 127 lines, then confirm all 128 blocks stay resident.
        for (int i = 0; i < 127; i++) access(0, 16'(32'h1000 + i * 16), 8'h00, "R4");
        access(0, 16'h1238, 8'h00, "R4");
        for (int i = 0; i < 127; i++) access(0, 16'(32'h1003 + i * 16), 8'h00, "R4");

        // Full: pointer picks line 0 (dirty, block 0x123), then line 1 (clean).
        access(0, 16'h8000, 8'h00, "R6");
        access(0, 16'h8010, 8'h00, "R7");
        access(0, 16'h1234, 8'h00, "R5");   // evicted earlier: misses
        access(0, 16'h1004, 8'h00, "R5");   // block 0x100 was line 1: misses
        access(0, 16'h1030, 8'h00, "R5");   // block 0x103 still resident: hits

        // Write miss allocates, merges, and reads back.
        access(1, 16'h9007, 8'h3C, "R8");
        access(0, 16'h9007, 8'h00, "R8");
        access(0, 16'h9000, 8'h00, "R8");

        // Random mix over more blocks than lines.
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] a;
            a = 16'(32'hA000 + ($urandom % 200) * 16 + ($urandom % 16));
            access(($urandom % 3) == 0, a, 8'($urandom), "");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule